// File: doc/BRIEF.md
# Single-Bit Hamming Sector Code Generator and Corrector

This block guards one sector of flash data with a 24-bit Hamming-style code. Bytes stream in one per cycle after a start pulse. For every set data bit, each bit of that bit's 12-bit position (byte index in the upper 9 bits, bit-in-byte in the lower 3) steers the bit into one of two 12-bit parity halves. The position bit selects the odd half when it is 1 and the even half when it is 0. Once the final byte of the sector has arrived, the two halves are joined and inverted. The result is the code that would be stored beside the sector. Because of the inversion, a fully erased sector (every byte 0xFF) yields an all-ones code and reads back as valid.

On the same pulse the block compares the freshly computed code with a stored code supplied by the caller. It classifies the outcome as clean, a repairable data-bit error, a fault inside the stored code itself, or uncorrectable. For a data error it reports the byte and bit position of the fault. A combinational read-modify port then flips that bit in whichever byte the caller presents at that index. The flash bus and the sector buffer stay outside the block.

Top module: `hamming_sector_ecc`

## Requirements
- R1: After reset, `done` is 0, `status` is 0 (clean), `code_out` is 0, `err_byte`/`err_bit` are 0 and `fix_out` equals `fix_in`.
- R2: `done` pulses for exactly one cycle, one cycle after the edge that accepts byte number SECTOR_BYTES. In that cycle `code_out` is the bitwise inverse of {odd half, even half}. The odd half sits in `code_out[23:12]` and the even half in `code_out[11:0]`. Parity bit k of a half covers every set data bit whose 12-bit position {byte index, bit index} has bit k equal to 1 (odd) or 0 (even). The low code byte is `code_out[7:0]`, the middle byte is `[15:8]` and the high byte is `[23:16]`.
- R3: A sector of all 0xFF bytes produces `code_out` = 0xFFFFFF.
- R4: `start` clears the parity halves and the byte counter. A byte offered in the same cycle as `start` is discarded.
- R5: Bytes offered after the final byte of a sector and before the next `start` are ignored: no further `done` and no change to `code_out`.
- R6: `status` = 0 (clean) when `stored_code` (sampled in the cycle of the final byte) equals the computed code.
- R7: When the two 12-bit halves of diff = `stored_code` XOR computed code are exact complements, and diff[23:15] < SECTOR_BYTES, then `status` = 1 (data corrected), `err_byte` = diff[23:15] and `err_bit` = diff[14:12]. For any other status both fields read 0.
- R8: When the halves of diff are complements but diff[23:15] >= SECTOR_BYTES, `status` = 3 (uncorrectable).
- R9: When diff has exactly one bit set, `status` = 2 (fault in the stored code) and no data byte is altered.
- R10: Any other nonzero diff gives `status` = 3.
- R11: `fix_out` = `fix_in` with bit `err_bit` inverted when `status` = 1 and `fix_idx` = `err_byte`. In every other case `fix_out` = `fix_in`. The path is combinational.
- R12: `code_out`, `status`, `err_byte` and `err_bit` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the parity halves and the byte counter for a new sector |
| in_valid | input | 1 | `in_byte` carries a sector byte this cycle |
| in_byte | input | 8 | Sector data byte |
| stored_code | input | 24 | Code read back from storage, sampled with the final byte |
| done | output | 1 | One-cycle pulse: results below are fresh |
| code_out | output | 24 | Inverted packed code of the sector just streamed |
| status | output | 2 | 0 clean, 1 data corrected, 2 code fault, 3 uncorrectable |
| err_byte | output | 9 | Byte index of the faulty data bit |
| err_bit | output | 3 | Bit position of the faulty data bit |
| fix_idx | input | 9 | Index of the byte presented on `fix_in` |
| fix_in | input | 8 | Byte to repair |
| fix_out | output | 8 | Repaired byte |

## Verification
Every registered result (`done`, `code_out`, `status`, `err_byte`, `err_bit`) is due exactly one cycle after the rising edge that accepts the final byte, and `fix_out` follows `fix_idx`/`fix_in` within the same cycle. The bench drives all inputs on the falling edge. It reads the results on the falling edge that directly follows the final byte's rising edge, then confirms one falling edge later that `done` has dropped while the results hold. A 512-byte instance checks the erased, clean, single-flip, code-fault and double-flip cases. A 12-byte instance with 4-bit byte addressing sweeps every single data-bit flip, every single code-bit flip and every out-of-range complement pattern against codes computed arithmetically in the bench.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

   localparam int LANE_BITS   = 8;
   localparam int LANE_ADDR_W = 3;

   typedef enum logic [1:0] {
      ECC_CLEAN      = 2'd0,
      ECC_FIXED      = 2'd1,
      ECC_CODE_FAULT = 2'd2,
      ECC_BROKEN     = 2'd3
   } ecc_status_e;

   // Lanes of a byte whose in-byte position has bit k set.
   function automatic logic [LANE_BITS-1:0] lane_mask(input int k);
      logic [LANE_BITS-1:0] m;
      for (int j = 0; j < LANE_BITS; j++) m[j] = ((j >> k) & 1) != 0;
      return m;
   endfunction

endpackage

// File: rtl/hsc_parity_accum.sv
module hsc_parity_accum
   import hsc_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int ADDR_W       = 9,
   localparam int HALF_W      = LANE_ADDR_W + ADDR_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 in_valid,
   input  logic [LANE_BITS-1:0] in_byte,
   output logic [HALF_W-1:0]    odd_next,
   output logic [HALF_W-1:0]    even_next,
   output logic                 last_beat
);

   localparam int CNT_W = $clog2(SECTOR_BYTES + 1);

   logic [CNT_W-1:0]  count;
   logic [HALF_W-1:0] odd_q, even_q, odd_c, even_c;
   logic [ADDR_W-1:0] byte_addr;
   logic              accept, byte_par;

   assign accept    = in_valid && !clear && (count < CNT_W'(SECTOR_BYTES));
   assign last_beat = accept && (count == CNT_W'(SECTOR_BYTES - 1));
   assign byte_addr = ADDR_W'(count);
   assign byte_par  = ^in_byte;

   // In-byte position bits: parity over the lanes selected by each mask.
   for (genvar k = 0; k < LANE_ADDR_W; k++) begin : g_lane_bits
      assign odd_c[k]  = accept & (^(in_byte &  lane_mask(k)));
      assign even_c[k] = accept & (^(in_byte & ~lane_mask(k)));
   end

   // Byte-index bits: whole-byte parity steered by the counter bit.
   for (genvar k = 0; k < ADDR_W; k++) begin : g_addr_bits
      assign odd_c[LANE_ADDR_W+k]  = accept & byte_par &  byte_addr[k];
      assign even_c[LANE_ADDR_W+k] = accept & byte_par & ~byte_addr[k];
   end

   assign odd_next  = odd_q  ^ odd_c;
   assign even_next = even_q ^ even_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         odd_q  <= '0;
         even_q <= '0;
      end else if (clear) begin
         count  <= '0;
         odd_q  <= '0;
         even_q <= '0;
      end else if (accept) begin
         count  <= count + 1'b1;
         odd_q  <= odd_next;
         even_q <= even_next;
      end
   end

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(SECTOR_BYTES));

   assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0 && odd_q == '0 && even_q == '0));

   assert_full_sector_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(SECTOR_BYTES) && !clear) |=> ($stable(odd_q) && $stable(even_q)));

endmodule

// File: rtl/hsc_syndrome.sv
module hsc_syndrome
   import hsc_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int ADDR_W       = 9,
   localparam int HALF_W      = LANE_ADDR_W + ADDR_W,
   localparam int CODE_W      = 2 * HALF_W
) (
   input  logic [CODE_W-1:0]      stored,
   input  logic [CODE_W-1:0]      calc,
   output ecc_status_e            status,
   output logic [ADDR_W-1:0]      err_byte,
   output logic [LANE_ADDR_W-1:0] err_bit
);

   logic [CODE_W-1:0] diff;
   logic [HALF_W-1:0] lo, hi;
   logic [ADDR_W-1:0] pos;
   logic              complement, single, in_range;

   assign diff       = stored ^ calc;
   assign lo         = diff[HALF_W-1:0];
   assign hi         = diff[CODE_W-1:HALF_W];
   assign pos        = hi[HALF_W-1:LANE_ADDR_W];
   assign complement = (lo ^ hi) == {HALF_W{1'b1}};
   assign single     = (diff & (diff - CODE_W'(1))) == '0;
   assign in_range   = 32'(pos) < SECTOR_BYTES;

   always_comb begin
      status   = ECC_BROKEN;
      err_byte = '0;
      err_bit  = '0;
      if (diff == '0) begin
         status = ECC_CLEAN;
      end else if (complement) begin
         if (in_range) begin
            status   = ECC_FIXED;
            err_byte = pos;
            err_bit  = hi[LANE_ADDR_W-1:0];
         end
      end else if (single) begin
         status = ECC_CODE_FAULT;
      end
   end

endmodule

// File: rtl/hsc_bit_fix.sv
module hsc_bit_fix
   import hsc_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  ecc_status_e            status,
   input  logic [ADDR_W-1:0]      err_byte,
   input  logic [LANE_ADDR_W-1:0] err_bit,
   input  logic [ADDR_W-1:0]      fix_idx,
   input  logic [LANE_BITS-1:0]   fix_in,
   output logic [LANE_BITS-1:0]   fix_out
);

   logic                 hit;
   logic [LANE_BITS-1:0] flip;

   assign hit     = (status == ECC_FIXED) && (fix_idx == err_byte);
   assign flip    = hit ? (LANE_BITS'(1) << err_bit) : '0;
   assign fix_out = fix_in ^ flip;

endmodule

// File: rtl/hamming_sector_ecc.sv
module hamming_sector_ecc
   import hsc_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int ADDR_W       = 9,
   localparam int HALF_W      = LANE_ADDR_W + ADDR_W,
   localparam int CODE_W      = 2 * HALF_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   in_valid,
   input  logic [LANE_BITS-1:0]   in_byte,
   input  logic [CODE_W-1:0]      stored_code,
   output logic                   done,
   output logic [CODE_W-1:0]      code_out,
   output logic [1:0]             status,
   output logic [ADDR_W-1:0]      err_byte,
   output logic [LANE_ADDR_W-1:0] err_bit,
   input  logic [ADDR_W-1:0]      fix_idx,
   input  logic [LANE_BITS-1:0]   fix_in,
   output logic [LANE_BITS-1:0]   fix_out
);

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("hamming_sector_ecc: ADDR_W out of range");
   end
   if (SECTOR_BYTES < 2 || SECTOR_BYTES > (1 << ADDR_W)) begin : g_bad_sector
      $error("hamming_sector_ecc: SECTOR_BYTES must fit the byte index field");
   end

   logic [HALF_W-1:0]      odd_next, even_next;
   logic                   last_beat;
   logic [CODE_W-1:0]      calc_code;
   ecc_status_e            cls_status, status_q;
   logic [ADDR_W-1:0]      cls_byte;
   logic [LANE_ADDR_W-1:0] cls_bit;

   hsc_parity_accum #(.SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W)) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start),
      .in_valid  (in_valid),
      .in_byte   (in_byte),
      .odd_next  (odd_next),
      .even_next (even_next),
      .last_beat (last_beat)
   );

   // Inverted so that an erased sector carries a matching all-ones code.
   assign calc_code = ~{odd_next, even_next};

   hsc_syndrome #(.SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W)) u_syndrome (
      .stored   (stored_code),
      .calc     (calc_code),
      .status   (cls_status),
      .err_byte (cls_byte),
      .err_bit  (cls_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         code_out <= '0;
         status_q <= ECC_CLEAN;
         err_byte <= '0;
         err_bit  <= '0;
      end else begin
         done <= last_beat;
         if (last_beat) begin
            code_out <= calc_code;
            status_q <= cls_status;
            err_byte <= cls_byte;
            err_bit  <= cls_bit;
         end
      end
   end

   assign status = status_q;

   hsc_bit_fix #(.ADDR_W(ADDR_W)) u_fix (
      .status   (status_q),
      .err_byte (err_byte),
      .err_bit  (err_bit),
      .fix_idx  (fix_idx),
      .fix_in   (fix_in),
      .fix_out  (fix_out)
   );

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_clean_matches_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status_q == ECC_CLEAN) |-> code_out == $past(stored_code));

   assert_fixed_index_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q == ECC_FIXED) |-> (32'(err_byte) < SECTOR_BYTES));

   assert_results_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !last_beat |=> ($stable(code_out) && $stable(status_q) && $stable(err_byte)));

   assert_fix_at_most_one_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fix_out ^ fix_in) <= 1);

   assert_no_fix_unless_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q != ECC_FIXED) |-> (fix_out == fix_in));

endmodule

// File: tb/hamming_sector_ecc_bench.sv
module hamming_sector_ecc_bench;

   localparam int BN = 512, BA = 9, BC = 24;
   localparam int SN = 12,  SA = 4, SC = 14;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          b_start = 0, b_valid = 0;
   logic [7:0]    b_byte = 0, b_fix_in = 0, b_fix_out;
   logic [BC-1:0] b_stored = 0, b_code;
   logic          b_done;
   logic [1:0]    b_status;
   logic [BA-1:0] b_err_byte, b_fix_idx = 0;
   logic [2:0]    b_err_bit;

   logic          s_start = 0, s_valid = 0;
   logic [7:0]    s_byte = 0, s_fix_in = 0, s_fix_out;
   logic [SC-1:0] s_stored = 0, s_code;
   logic          s_done;
   logic [1:0]    s_status;
   logic [SA-1:0] s_err_byte, s_fix_idx = 0;
   logic [2:0]    s_err_bit;

   hamming_sector_ecc #(.SECTOR_BYTES(BN), .ADDR_W(BA)) u_hamming_sector_ecc (
      .clk(clk), .rst_n(rst_n), .start(b_start), .in_valid(b_valid), .in_byte(b_byte),
      .stored_code(b_stored), .done(b_done), .code_out(b_code), .status(b_status),
      .err_byte(b_err_byte), .err_bit(b_err_bit), .fix_idx(b_fix_idx),
      .fix_in(b_fix_in), .fix_out(b_fix_out));

   hamming_sector_ecc #(.SECTOR_BYTES(SN), .ADDR_W(SA)) u_hamming_sector_ecc_small (
      .clk(clk), .rst_n(rst_n), .start(s_start), .in_valid(s_valid), .in_byte(s_byte),
      .stored_code(s_stored), .done(s_done), .code_out(s_code), .status(s_status),
      .err_byte(s_err_byte), .err_bit(s_err_bit), .fix_idx(s_fix_idx),
      .fix_in(s_fix_in), .fix_out(s_fix_out));

   int n_checks = 0, n_fail = 0;
   bit finished = 0;
   logic [7:0] dat [BN];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Code from the requirement: each set bit's position bits steer it.
   function automatic logic [31:0] model_code(input int n, input int aw);
      int h, a;
      logic [31:0] odd, even;
      h = 3 + aw; odd = 0; even = 0;
      for (int i = 0; i < n; i++)
         for (int j = 0; j < 8; j++)
            if (dat[i][j]) begin
               a = i * 8 + j;
               for (int k = 0; k < h; k++)
                  if (((a >> k) & 1) != 0) odd[k] = ~odd[k];
                  else even[k] = ~even[k];
            end
      return ~((odd << h) | even) & ((32'd1 << (2 * h)) - 1);
   endfunction

   task automatic run_big(input logic [BC-1:0] st, input bit do_start);
      b_stored = st;
      if (do_start) begin
         b_start = 1; @(negedge clk); b_start = 0;
      end
      for (int i = 0; i < BN; i++) begin
         b_valid = 1; b_byte = dat[i]; @(negedge clk);
      end
      b_valid = 0;
   endtask

   task automatic run_small(input logic [SC-1:0] st);
      s_stored = st;
      s_start = 1; @(negedge clk); s_start = 0;
      for (int i = 0; i < SN; i++) begin
         s_valid = 1; s_byte = dat[i]; @(negedge clk);
      end
      s_valid = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] ref_code, ref2;
      logic [7:0]  good;
      logic [6:0]  hi7;
      int f, g;
      repeat (3) @(negedge clk);
      b_fix_in = 8'h5A; b_fix_idx = 9'd3;
      @(negedge clk);
      chk("R1 done", 32'(b_done), 0);
      chk("R1 status", 32'(b_status), 0);
      chk("R1 code", 32'(b_code), 0);
      chk("R1 fix", 32'(b_fix_out), 32'h5A);
      rst_n = 1;
      @(negedge clk);

      // R3 erased sector
      for (int i = 0; i < BN; i++) dat[i] = 8'hFF;
      run_big(24'hFFFFFF, 1);
      chk("R2 done pulse", 32'(b_done), 1);
      chk("R3 erased code", 32'(b_code), 32'hFFFFFF);
      chk("R6 erased clean", 32'(b_status), 0);
      @(negedge clk);
      chk("R2 done drops", 32'(b_done), 0);

      // R2 R6 patterned sector
      for (int i = 0; i < BN; i++) dat[i] = 8'((i * 37 + 11) ^ (i >> 3));
      ref_code = model_code(BN, BA);
      run_big(BC'(ref_code), 1);
      chk("R2 pattern code", 32'(b_code), ref_code);
      chk("R6 pattern clean", 32'(b_status), 0);

      // R7 R11 single data flip at byte 300 bit 5
      good = dat[300];
      dat[300][5] = ~dat[300][5];
      run_big(BC'(ref_code), 1);
      chk("R7 status", 32'(b_status), 1);
      chk("R7 byte", 32'(b_err_byte), 300);
      chk("R7 bit", 32'(b_err_bit), 5);
      b_fix_idx = 9'd300; b_fix_in = dat[300]; #1;
      chk("R11 repaired", 32'(b_fix_out), 32'(good));
      b_fix_idx = 9'd299; b_fix_in = dat[299]; #1;
      chk("R11 other byte", 32'(b_fix_out), 32'(dat[299]));

      // R5 R12 extra bytes ignored, results held
      ref2 = 32'(b_code);
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         b_valid = 1; b_byte = 8'(i + 1); @(negedge clk);
         chk("R5 no extra done", 32'(b_done), 0);
      end
      b_valid = 0; @(negedge clk);
      chk("R5 code held", 32'(b_code), ref2);
      chk("R12 status held", 32'(b_status), 1);
      chk("R12 byte held", 32'(b_err_byte), 300);

      // R4 start with a byte in the same cycle: byte discarded
      dat[300] = good;
      b_start = 1; b_valid = 1; b_byte = 8'hA5; @(negedge clk);
      b_start = 0;
      run_big(BC'(ref_code), 0);
      chk("R4 code after start", 32'(b_code), ref_code);
      chk("R4 clean after start", 32'(b_status), 0);

      // R9 code fault
      run_big(BC'(ref_code ^ 32'h20000), 1);
      chk("R9 status", 32'(b_status), 2);
      b_fix_idx = 9'd17; b_fix_in = 8'h3C; #1;
      chk("R9 no data change", 32'(b_fix_out), 32'h3C);

      // R10 two data flips
      dat[5][1] = ~dat[5][1]; dat[400][6] = ~dat[400][6];
      run_big(BC'(ref_code), 1);
      chk("R10 double flip", 32'(b_status), 3);
      chk("R7 fields zero", 32'(b_err_byte), 0);

      // Small instance: exhaustive single data flips (R7 R11)
      for (int i = 0; i < SN; i++) dat[i] = 8'(i * 29 + 7);
      ref_code = model_code(SN, SA);
      for (f = 0; f < SN * 8; f++) begin
         dat[f / 8][f % 8] = ~dat[f / 8][f % 8];
         run_small(SC'(ref_code));
         chk("R7 sweep status", 32'(s_status), 1);
         chk("R7 sweep byte", 32'(s_err_byte), 32'(f / 8));
         chk("R7 sweep bit", 32'(s_err_bit), 32'(f % 8));
         s_fix_idx = SA'(f / 8); s_fix_in = dat[f / 8]; #1;
         dat[f / 8][f % 8] = ~dat[f / 8][f % 8];
         chk("R11 sweep repair", 32'(s_fix_out), 32'(dat[f / 8]));
      end
      // R9 every single code bit
      for (int c = 0; c < SC; c++) begin
         run_small(SC'(ref_code ^ (32'd1 << c)));
         chk("R9 sweep status", 32'(s_status), 2);
         chk("R2 small code", 32'(s_code), ref_code);
      end
      // R8 complement pattern beyond the sector
      for (int b = SN; b < 16; b++)
         for (int t = 0; t < 8; t++) begin
            hi7 = 7'(b * 8 + t);
            run_small(SC'(ref_code) ^ {hi7, ~hi7});
            chk("R8 out of range", 32'(s_status), 3);
         end
      // R10 double flips
      for (int p = 0; p < 20; p++) begin
         f = p * 5; g = (p * 11 + 3) % (SN * 8);
         if (f != g) begin
            dat[f / 8][f % 8] = ~dat[f / 8][f % 8];
            dat[g / 8][g % 8] = ~dat[g / 8][g % 8];
            run_small(SC'(ref_code));
            chk("R10 sweep double", 32'(s_status), 3);
            dat[f / 8][f % 8] = ~dat[f / 8][f % 8];
            dat[g / 8][g % 8] = ~dat[g / 8][g % 8];
         end
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule